// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block runs block loads and block stores of up to sixteen registers against a data cache whose port is two words wide. The execute stage presents a base address, a sixteen-bit register mask and a direction flag. The block sends the first cache access for the instruction in the same cycle. Once that access is taken, the instruction leaves the execute stage. The block then runs the remaining accesses on its own, one per cycle, and each access moves one or two registers. Load data comes back to the register file one cycle after the cache access, through a write-back port that carries up to two register indices.

A load access that misses is parked in a single pending-miss slot, and the sequence moves on. Accesses issued after the miss that hit are still served. When the missing data arrives on the fill port, it is written to the registers recorded in the slot and the slot is emptied. Two status outputs tell the hazard logic that a background transfer is running and that the pending-miss slot is taken. Stores are treated as always complete, because a write buffer absorbs store misses.

Top module: `lsm_seq`

## Requirements
- R1: Registers are moved in ascending index order. Each access carries the lowest remaining register on the low word (bits 31:0) and, if another register remains, the next one on the high word (bits 63:32). `cache_pair` is high exactly when two registers are carried.
- R2: The address of each access equals the base address plus 4 times the number of registers already moved.
- R3: For a load access that hits, the cycle after the access shows `wb_en[0]`=1, `wb_en[1]`=`cache_pair`, the register indices of that access, and the cache read data on `wb_data`.
- R4: The first access of an instruction goes out in the cycle the request is presented, with `ex_stall` low. Any further accesses run with `xfer_busy` high. A memory request presented while `xfer_busy` is high sees `ex_stall` high and is not taken.
- R5: An empty register mask is taken in one cycle with `ex_stall` low. It makes no cache access, and `xfer_busy` stays low.
- R6: A load access that misses while the slot is free is consumed. It sets `miss_pending`, produces no write-back, and the sequence goes on with its next access.
- R7: A load access that misses while `miss_pending` is high is not consumed. The same address is issued again in the next cycle, and a first access blocked this way holds `ex_stall` high.
- R8: In a cycle with `fill_valid` high, no cache access is made. If the slot is taken, the next cycle writes `fill_data` to the slot's registers and clears `miss_pending`. A fill with no slot taken produces no write-back.
- R9: A store access has `cache_we` high and takes its data from the register read ports (`rf_ridx0`/`rf_ridx1`). The unused high word is zero, and the access completes whatever `cache_hit` shows.
- R10: After reset `xfer_busy`, `miss_pending`, `wb_en` and `cache_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Memory instruction presented by the execute stage |
| req_load | input | 1 | 1 = load, 0 = store |
| req_base | input | 32 | Base byte address |
| req_list | input | 16 | Register mask, bit n = register n |
| ex_stall | output | 1 | Request cannot be taken this cycle |
| xfer_busy | output | 1 | Background transfer in progress |
| miss_pending | output | 1 | Pending-miss slot is taken |
| cache_req | output | 1 | Cache access this cycle |
| cache_we | output | 1 | Access is a store |
| cache_pair | output | 1 | Access carries two registers |
| cache_addr | output | 32 | Access byte address |
| cache_wdata | output | 64 | Store data |
| cache_hit | input | 1 | Access hits (same cycle) |
| cache_rdata | input | 64 | Load data (same cycle) |
| fill_valid | input | 1 | Missing data returns |
| fill_data | input | 64 | Returned miss data |
| rf_ridx0 | output | 4 | Register read index, low word |
| rf_ridx1 | output | 4 | Register read index, high word |
| rf_rdata0 | input | 32 | Register read data, low word |
| rf_rdata1 | input | 32 | Register read data, high word |
| wb_en | output | 2 | Write-back enables, bit 0 low word, bit 1 high word |
| wb_idx0 | output | 4 | Write-back register, low word |
| wb_idx1 | output | 4 | Write-back register, high word |
| wb_data | output | 64 | Write-back data |

## Verification
Two events can compete in the same cycle: a returning fill and the next access of a transfer, whose write-back would use the same port one cycle later. The bench raises `fill_valid` while a request is waiting behind a full slot. It checks that no cache access goes out in that cycle, that the following cycle writes back the parked registers with the fill data, and that the held request is then taken in the next cycle. A second case pairs a background access that misses with a full slot. There the bench checks that the address repeats until a hit lets the access complete.

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW    = $clog2(NREG),
  localparam int BYTES = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_load,
  input  logic [AW-1:0]   req_base,
  input  logic [NREG-1:0] req_list,
  output logic            ex_stall,
  output logic            xfer_busy,
  output logic            miss_pending,
  output logic            cache_req,
  output logic            cache_we,
  output logic            cache_pair,
  output logic [AW-1:0]   cache_addr,
  output logic [2*DW-1:0] cache_wdata,
  input  logic            cache_hit,
  input  logic [2*DW-1:0] cache_rdata,
  input  logic            fill_valid,
  input  logic [2*DW-1:0] fill_data,
  output logic [IW-1:0]   rf_ridx0,
  output logic [IW-1:0]   rf_ridx1,
  input  logic [DW-1:0]   rf_rdata0,
  input  logic [DW-1:0]   rf_rdata1,
  output logic [1:0]      wb_en,
  output logic [IW-1:0]   wb_idx0,
  output logic [IW-1:0]   wb_idx1,
  output logic [2*DW-1:0] wb_data
);

  function automatic logic [IW-1:0] enc(input logic [NREG-1:0] oh);
    enc = '0;
    for (int i = 0; i < NREG; i++)
      if (oh[i]) enc = IW'(i);
  endfunction

  logic            active, act_load;
  logic [NREG-1:0] rem;
  logic [AW-1:0]   cur_addr;
  logic            slot_v, slot_pair;
  logic [IW-1:0]   slot_i0, slot_i1;

  logic [NREG-1:0] src_list, low1, rest1, low2, left;
  logic [AW-1:0]   src_addr;
  logic            src_load, two, want, blocked, beat_done, accept;

  assign src_list = active ? rem      : req_list;
  assign src_addr = active ? cur_addr : req_base;
  assign src_load = active ? act_load : req_load;

  assign low1  = src_list & (~src_list + 1'b1);
  assign rest1 = src_list & ~low1;
  assign low2  = rest1 & (~rest1 + 1'b1);
  assign two   = |rest1;
  assign left  = two ? (rest1 & ~low2) : rest1;

  assign want      = active || (req_valid && |req_list);
  assign cache_req = want && !fill_valid;
  assign cache_we  = cache_req && !src_load;
  assign blocked   = src_load && !cache_hit && slot_v;
  assign beat_done = cache_req && !blocked;
  assign accept    = req_valid && !active && (~|req_list || beat_done);
  assign ex_stall  = req_valid && !accept;

  assign cache_pair  = two;
  assign cache_addr  = src_addr;
  assign rf_ridx0    = enc(low1);
  assign rf_ridx1    = enc(low2);
  assign cache_wdata = {two ? rf_rdata1 : {DW{1'b0}}, rf_rdata0};

  assign xfer_busy    = active;
  assign miss_pending = slot_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      act_load  <= 1'b0;
      rem       <= '0;
      cur_addr  <= '0;
      slot_v    <= 1'b0;
      slot_pair <= 1'b0;
      slot_i0   <= '0;
      slot_i1   <= '0;
      wb_en     <= '0;
      wb_idx0   <= '0;
      wb_idx1   <= '0;
      wb_data   <= '0;
    end else begin
      if (beat_done) begin
        rem      <= left;
        cur_addr <= src_addr + AW'(two ? 2*BYTES : BYTES);
        active   <= |left;
        act_load <= src_load;
      end
      wb_en <= '0;
      if (fill_valid && slot_v) begin
        wb_en   <= {slot_pair, 1'b1};
        wb_idx0 <= slot_i0;
        wb_idx1 <= slot_i1;
        wb_data <= fill_data;
        slot_v  <= 1'b0;
      end else if (beat_done && src_load && cache_hit) begin
        wb_en   <= {two, 1'b1};
        wb_idx0 <= rf_ridx0;
        wb_idx1 <= rf_ridx1;
        wb_data <= cache_rdata;
      end
      if (beat_done && src_load && !cache_hit) begin
        slot_v    <= 1'b1;
        slot_pair <= two;
        slot_i0   <= rf_ridx0;
        slot_i1   <= rf_ridx1;
      end
    end
  end

endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            ex_stall,
  input logic            xfer_busy,
  input logic            miss_pending,
  input logic            cache_req,
  input logic            cache_we,
  input logic            cache_pair,
  input logic [AW-1:0]   cache_addr,
  input logic [2*DW-1:0] cache_wdata,
  input logic            cache_hit,
  input logic            fill_valid,
  input logic [1:0]      wb_en
);

  assert_fill_no_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !cache_req);

  assert_fill_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && miss_pending |=> !miss_pending);

  assert_busy_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy && req_valid |-> ex_stall);

  assert_hit_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cache_req && !cache_we && cache_hit |=> wb_en[0] && (wb_en[1] == $past(cache_pair)));

  assert_miss_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cache_req && !cache_we && !cache_hit |=> wb_en == 2'b00);

  assert_retry_same_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy && cache_req && !cache_we && !cache_hit && miss_pending
      |=> xfer_busy && cache_addr == $past(cache_addr));

  assert_store_high_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we && !cache_pair |-> cache_wdata[2*DW-1:DW] == '0);

endmodule

bind lsm_seq lsm_seq_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/lsm_seq_tb_top.sv
module lsm_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] K = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_load = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_list = '0;
  logic        ex_stall, xfer_busy, miss_pending, cache_req, cache_we, cache_pair;
  logic [31:0] cache_addr;
  logic [63:0] cache_wdata, cache_rdata, wb_data;
  logic        cache_hit = 1'b1, fill_valid = 1'b0;
  logic [63:0] fill_data = '0;
  logic [3:0]  rf_ridx0, rf_ridx1, wb_idx0, wb_idx1;
  logic [31:0] rf_rdata0, rf_rdata1;
  logic [1:0]  wb_en;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_rdata0   = 32'hC000_0000 | 32'(rf_ridx0);
  assign rf_rdata1   = 32'hC000_0000 | 32'(rf_ridx1);
  assign cache_rdata = {(cache_addr + 32'd4) ^ K, cache_addr ^ K};

  lsm_seq dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  localparam int NV = 6;
  localparam logic [56:0] VEC [NV] = '{
    {16'h0001, 32'h0000_0040, 4'd0,  4'd0,  1'b0},
    {16'h8000, 32'h0000_0080, 4'd15, 4'd0,  1'b0},
    {16'h0003, 32'h0000_00C0, 4'd0,  4'd1,  1'b1},
    {16'h8001, 32'h0000_0100, 4'd0,  4'd15, 1'b1},
    {16'h0410, 32'h0000_0140, 4'd4,  4'd10, 1'b1},
    {16'hFFFF, 32'h0000_0180, 4'd0,  4'd1,  1'b1}
  };

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    #1;
    chk("R10 busy", 64'(xfer_busy), 0);
    chk("R10 miss_pending", 64'(miss_pending), 0);
    chk("R10 wb_en", 64'(wb_en), 0);
    chk("R10 cache_req", 64'(cache_req), 0);

    // Store vectors: first access shape, then count accesses to completion (R1, R9)
    for (int v = 0; v < NV; v++) begin
      int beats;
      logic [15:0] l;
      logic [3:0] i0, i1;
      logic p;
      l = VEC[v][56:41]; i0 = VEC[v][8:5]; i1 = VEC[v][4:1]; p = VEC[v][0];
      req_valid = 1'b1; req_load = 1'b0; req_list = l; req_base = VEC[v][40:9];
      cache_hit = 1'b0;
      #1;
      chk("R9 store we", 64'(cache_we), 1);
      chk("R4 first access no stall", 64'(ex_stall), 0);
      chk("R2 first addr", 64'(cache_addr), 64'(VEC[v][40:9]));
      chk("R1 pair", 64'(cache_pair), 64'(p));
      chk("R1 idx0", 64'(rf_ridx0), 64'(i0));
      if (p) chk("R1 idx1", 64'(rf_ridx1), 64'(i1));
      chk("R9 wdata", cache_wdata,
          {p ? (32'hC000_0000 | 32'(i1)) : 32'h0, 32'hC000_0000 | 32'(i0)});
      beats = 1;
      tick();
      req_valid = 1'b0;
      for (int c = 0; c < 20 && xfer_busy; c++) begin
        beats++;
        tick();
      end
      chk("R1 access count", 64'(beats), 64'(($countones(l) + 1) / 2));
      chk("R9 store no slot", 64'(miss_pending), 0);
    end
    cache_hit = 1'b1;

    // Load multiple, all hits: regs 0,2,4,5,7 (R1 R2 R3 R4)
    req_valid = 1'b1; req_load = 1'b1; req_list = 16'h00B5; req_base = 32'h100;
    #1;
    chk("R4 no stall on first", 64'(ex_stall), 0);
    chk("R2 addr0", 64'(cache_addr), 64'h100);
    tick();
    req_list = 16'h0002; req_base = 32'h200;
    #1;
    chk("R3 wb_en", 64'(wb_en), 3);
    chk("R3 wb idx", {wb_idx1, wb_idx0}, {4'd2, 4'd0});
    chk("R3 wb data", wb_data, {32'h104 ^ K, 32'h100 ^ K});
    chk("R4 busy", 64'(xfer_busy), 1);
    chk("R4 held request", 64'(ex_stall), 1);
    chk("R2 addr1", 64'(cache_addr), 64'h108);
    chk("R1 second pair", {rf_ridx1, rf_ridx0}, {4'd5, 4'd4});
    tick();
    chk("R3 wb idx beat2", {wb_idx1, wb_idx0}, {4'd5, 4'd4});
    chk("R3 wb data beat2", wb_data, {32'h10C ^ K, 32'h108 ^ K});
    chk("R2 addr2", 64'(cache_addr), 64'h110);
    chk("R1 last single", 64'(cache_pair), 0);
    chk("R4 still held", 64'(ex_stall), 1);
    tick();
    chk("R3 single wb_en", 64'(wb_en), 1);
    chk("R3 single idx", 64'(wb_idx0), 7);
    chk("R4 idle", 64'(xfer_busy), 0);
    chk("R4 held req now taken", 64'(ex_stall), 0);
    chk("R4 held req addr", 64'(cache_addr), 64'h200);
    tick();
    req_valid = 1'b0;
    chk("R4 held req wb", {60'(wb_idx0), 2'b0, wb_en}, {60'd1, 2'b0, 2'b01});

    // Empty mask (R5)
    req_valid = 1'b1; req_list = 16'h0;
    #1;
    chk("R5 no access", 64'(cache_req), 0);
    chk("R5 taken", 64'(ex_stall), 0);
    tick();
    req_valid = 1'b0;
    chk("R5 not busy", 64'(xfer_busy), 0);
    chk("R5 no wb", 64'(wb_en), 0);

    // Miss then hit under miss (R6), second miss blocked (R7), fill collision (R8)
    req_valid = 1'b1; req_load = 1'b1; req_list = 16'h004A; req_base = 32'h300; cache_hit = 1'b0;
    #1;
    chk("R6 first miss taken", 64'(ex_stall), 0);
    tick();
    req_valid = 1'b0; cache_hit = 1'b1;
    #1;
    chk("R6 slot taken", 64'(miss_pending), 1);
    chk("R6 no wb", 64'(wb_en), 0);
    chk("R6 continues", 64'(cache_addr), 64'h308);
    tick();
    chk("R6 hit under miss wb", {60'(wb_idx0), 2'b0, wb_en}, {60'd6, 2'b0, 2'b01});
    chk("R6 hit data", 64'(wb_data[31:0]), 64'(32'h308 ^ K));
    chk("R6 slot kept", 64'(miss_pending), 1);
    req_valid = 1'b1; req_list = 16'h0030; req_base = 32'h400; cache_hit = 1'b0;
    #1;
    chk("R7 first access blocked", 64'(ex_stall), 1);
    tick();
    chk("R7 not taken", 64'(xfer_busy), 0);
    chk("R7 no wb", 64'(wb_en), 0);
    fill_valid = 1'b1; fill_data = 64'h1111_2222_3333_4444;
    #1;
    chk("R8 no access on fill", 64'(cache_req), 0);
    chk("R8 still stalled", 64'(ex_stall), 1);
    tick();
    fill_valid = 1'b0;
    #1;
    chk("R8 fill wb_en", 64'(wb_en), 3);
    chk("R8 fill idx", {wb_idx1, wb_idx0}, {4'd3, 4'd1});
    chk("R8 fill data", wb_data, 64'h1111_2222_3333_4444);
    chk("R8 slot freed", 64'(miss_pending), 0);
    chk("R7 now taken", 64'(ex_stall), 0);
    tick();
    req_valid = 1'b0;
    chk("R6 new slot", 64'(miss_pending), 1);
    fill_valid = 1'b1; fill_data = 64'hAAAA_0005_BBBB_0004;
    tick();
    fill_valid = 1'b0;
    chk("R8 second fill idx", {wb_idx1, wb_idx0}, {4'd5, 4'd4});

    // Background access blocked by a full slot repeats its address (R7)
    req_valid = 1'b1; req_list = 16'h000F; req_base = 32'h500; cache_hit = 1'b0;
    tick();
    req_valid = 1'b0;
    chk("R7 bg addr", 64'(cache_addr), 64'h508);
    tick();
    chk("R7 bg repeat", 64'(cache_addr), 64'h508);
    chk("R7 bg busy", 64'(xfer_busy), 1);
    cache_hit = 1'b1;
    tick();
    chk("R7 bg completes", {60'({wb_idx1, wb_idx0}), 2'b0, wb_en}, {60'(8'h32), 2'b0, 2'b11});
    chk("R7 bg idle", 64'(xfer_busy), 0);
    fill_valid = 1'b1;
    tick();
    fill_valid = 1'b0;
    chk("R8 fill frees", 64'(miss_pending), 0);
    fill_valid = 1'b1;
    tick();
    fill_valid = 1'b0;
    chk("R8 fill without slot", 64'(wb_en), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule